// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits next to a two-port shared memory and turns accesses to its two highest words into message-passing interrupts. Each port (left and right) presents its decoded access every clock: address, active-low chip select, write strobe and output enable, plus an active-low busy input from the collision arbiter. The top address of the array belongs to the right port and the one below it to the left port. A port posts a message by writing the other port's mailbox, which raises the other port's interrupt. The owner acknowledges by reading its own mailbox, which drops its interrupt.

The block also holds the two mailbox words, 16 bits each by default. Either port can read either mailbox word back; the word appears on that port's read-data pins one clock after the read, qualified by a read-valid pin. Mailbox read data has no back-pressure: the valid pin is high for exactly one cycle per accepted read, and the consumer must take the word in that cycle. All other pins are plain level signals sampled on the rising clock edge.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is active and on the first cycle after it, both interrupt outputs are low (asserted), both read-valid outputs are low, and both mailbox words hold zero.
- R2: A write accepted from the left port to address all-ones drives the right interrupt low on the next cycle; a write accepted from the right port to address all-ones minus one drives the left interrupt low on the next cycle.
- R3: An accepted read by a port of its own mailbox (right: all-ones, left: all-ones minus one) drives that port's interrupt high on the next cycle, unless a set hits the same flag in that cycle.
- R4: A port reading the other port's mailbox leaves the other port's interrupt unchanged.
- R5: While a port's busy input is low, its write to the opposite mailbox neither sets the opposite interrupt nor changes the stored word.
- R6: While a port's busy input is low, its read of its own mailbox leaves its interrupt asserted and produces no read-valid pulse.
- R7: When a set and a clear hit the same interrupt in one cycle, the interrupt ends asserted (set wins); a read in that cycle returns the word stored before the write.
- R8: An access counts only with chip select low. A write needs the write strobe low; a read needs the write strobe high and the output enable low. Any other combination changes neither interrupt nor read-valid.
- R9: An accepted read of either mailbox address gives read-valid high on the next cycle with read data equal to the last accepted write to that address; any other cycle gives read-valid low.
- R10: Writes to non-mailbox addresses, and a port writing its own mailbox, change no interrupt; the own-mailbox write still stores its data.
- R11: If both ports write the same mailbox in one cycle with neither busy, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_addr | input | AW | Left port address |
| lt_cs_n | input | 1 | Left chip select, active low |
| lt_we_n | input | 1 | Left write strobe, active low |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_busy_n | input | 1 | Left busy from arbiter, active low |
| lt_wdata | input | DW | Left write data |
| lt_rdata | output | DW | Left mailbox read data |
| lt_rvalid | output | 1 | Left read data valid, one-cycle pulse |
| lt_irq_n | output | 1 | Left interrupt, active low |
| rt_addr | input | AW | Right port address |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_we_n | input | 1 | Right write strobe, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_busy_n | input | 1 | Right busy from arbiter, active low |
| rt_wdata | input | DW | Right write data |
| rt_rdata | output | DW | Right mailbox read data |
| rt_rvalid | output | 1 | Right read data valid, one-cycle pulse |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The properties assume every control pin is a clean synchronous level, settled before each rising edge and holding one access per port per cycle, and that reset is released away from a clock edge. They make no assumption about busy, so they also cover cycles where the arbiter blocks a port. The stimulus changes all inputs only on the falling edge, returns every port to idle (chip select high) after each access, and drives the collision and same-address cases deliberately in a single shared cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPORT  = 2;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic int peer(input int p);
    return (p == PORT_L) ? PORT_R : PORT_L;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]    addr,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             busy_n,
  output acc_e             acc,
  output logic [NPORT-1:0] box_hit
);
  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    acc = ACC_IDLE;
    if (!cs_n && busy_n) begin
      if (!we_n)      acc = ACC_WRITE;
      else if (!oe_n) acc = ACC_READ;
    end
  end

  always_comb begin
    box_hit         = '0;
    box_hit[PORT_L] = (addr == NEXT_ADDR);
    box_hit[PORT_R] = (addr == TOP_ADDR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b1;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          wr_en,
  input  logic [NPORT-1:0][DW-1:0]  wdata,
  output logic [DW-1:0]             word_q
);
  logic [DW-1:0] word_d;

  always_comb begin
    word_d = word_q;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wr_en[p]) word_d = wdata[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lt_addr,
  input  logic          lt_cs_n,
  input  logic          lt_we_n,
  input  logic          lt_oe_n,
  input  logic          lt_busy_n,
  input  logic [DW-1:0] lt_wdata,
  output logic [DW-1:0] lt_rdata,
  output logic          lt_rvalid,
  output logic          lt_irq_n,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_cs_n,
  input  logic          rt_we_n,
  input  logic          rt_oe_n,
  input  logic          rt_busy_n,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_rvalid,
  output logic          rt_irq_n
);
  logic [NPORT-1:0][AW-1:0]    addr_a;
  logic [NPORT-1:0]            cs_n_a, we_n_a, oe_n_a, busy_n_a;
  logic [NPORT-1:0][DW-1:0]    wdata_a;
  acc_e                        acc_a [NPORT];
  logic [NPORT-1:0][NPORT-1:0] hit_a;
  logic [NPORT-1:0][NPORT-1:0] wr_en_a;
  logic [NPORT-1:0][DW-1:0]    box_q;
  logic [NPORT-1:0][DW-1:0]    rdata_q;
  logic [NPORT-1:0]            rvalid_q;
  logic [NPORT-1:0]            irq_n_a;

  assign addr_a   = {rt_addr,   lt_addr};
  assign cs_n_a   = {rt_cs_n,   lt_cs_n};
  assign we_n_a   = {rt_we_n,   lt_we_n};
  assign oe_n_a   = {rt_oe_n,   lt_oe_n};
  assign busy_n_a = {rt_busy_n, lt_busy_n};
  assign wdata_a  = {rt_wdata,  lt_wdata};

  always_comb begin
    for (int b = 0; b < NPORT; b++) begin
      for (int p = 0; p < NPORT; p++) begin
        wr_en_a[b][p] = (acc_a[p] == ACC_WRITE) && hit_a[p][b];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int Q = peer(p);
    logic set_w, clr_w;

    mbx_decode #(.AW(AW)) u_dec (
      .addr    (addr_a[p]),
      .cs_n    (cs_n_a[p]),
      .we_n    (we_n_a[p]),
      .oe_n    (oe_n_a[p]),
      .busy_n  (busy_n_a[p]),
      .acc     (acc_a[p]),
      .box_hit (hit_a[p])
    );

    assign set_w = (acc_a[Q] == ACC_WRITE) && hit_a[Q][p];
    assign clr_w = (acc_a[p] == ACC_READ)  && hit_a[p][p];

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_w),
      .clr   (clr_w),
      .irq_n (irq_n_a[p])
    );

    mbx_store #(.DW(DW)) u_box (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_a[p]),
      .wdata  (wdata_a),
      .word_q (box_q[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rvalid_q[p] <= 1'b0;
        rdata_q[p]  <= '0;
      end else begin
        rvalid_q[p] <= (acc_a[p] == ACC_READ) && (|hit_a[p]);
        if ((acc_a[p] == ACC_READ) && (|hit_a[p]))
          rdata_q[p] <= hit_a[p][PORT_R] ? box_q[PORT_R] : box_q[PORT_L];
      end
    end
  end

  assign lt_irq_n  = irq_n_a[PORT_L];
  assign rt_irq_n  = irq_n_a[PORT_R];
  assign lt_rvalid = rvalid_q[PORT_L];
  assign rt_rvalid = rvalid_q[PORT_R];
  assign lt_rdata  = rdata_q[PORT_L];
  assign rt_rdata  = rdata_q[PORT_R];
endmodule

// File: rtl/mbx_irq_check.sv
module mbx_irq_check #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] lt_addr,
  input logic          lt_cs_n,
  input logic          lt_we_n,
  input logic          lt_oe_n,
  input logic          lt_busy_n,
  input logic          lt_rvalid,
  input logic          lt_irq_n,
  input logic [AW-1:0] rt_addr,
  input logic          rt_cs_n,
  input logic          rt_we_n,
  input logic          rt_oe_n,
  input logic          rt_busy_n,
  input logic          rt_rvalid,
  input logic          rt_irq_n
);
  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = RBOX - {{(AW-1){1'b0}}, 1'b1};

  logic l_wr, l_rd, r_wr, r_rd;
  logic set_l, set_r, clr_l, clr_r, l_box_rd, r_box_rd;

  assign l_wr  = !lt_cs_n && !lt_we_n && lt_busy_n;
  assign l_rd  = !lt_cs_n && lt_we_n && !lt_oe_n && lt_busy_n;
  assign r_wr  = !rt_cs_n && !rt_we_n && rt_busy_n;
  assign r_rd  = !rt_cs_n && rt_we_n && !rt_oe_n && rt_busy_n;
  assign set_l = r_wr && (rt_addr == LBOX);
  assign set_r = l_wr && (lt_addr == RBOX);
  assign clr_l = l_rd && (lt_addr == LBOX);
  assign clr_r = r_rd && (rt_addr == RBOX);
  assign l_box_rd = l_rd && ((lt_addr == LBOX) || (lt_addr == RBOX));
  assign r_box_rd = r_rd && ((rt_addr == LBOX) || (rt_addr == RBOX));

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lt_irq_n && !rt_irq_n && !lt_rvalid && !rt_rvalid));

  a_r2_set_left: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> !lt_irq_n);
  a_r2_set_right: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> !rt_irq_n);

  a_r3_clear_left: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> lt_irq_n);
  a_r3_clear_right: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> rt_irq_n);

  // covers R4, R5, R6, R8 and R10: with no accepted set or clear the flag holds
  a_r4_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l && !clr_l) |=> $stable(lt_irq_n));
  a_r4_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r && !clr_r) |=> $stable(rt_irq_n));

  a_r9_valid_left: assert property (@(posedge clk) disable iff (!rst_n)
    l_box_rd |=> lt_rvalid);
  a_r9_novalid_left: assert property (@(posedge clk) disable iff (!rst_n)
    !l_box_rd |=> !lt_rvalid);
  a_r9_valid_right: assert property (@(posedge clk) disable iff (!rst_n)
    r_box_rd |=> rt_rvalid);
  a_r9_novalid_right: assert property (@(posedge clk) disable iff (!rst_n)
    !r_box_rd |=> !rt_rvalid);
endmodule

bind mbx_irq_top mbx_irq_check #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lt_addr   (lt_addr),
  .lt_cs_n   (lt_cs_n),
  .lt_we_n   (lt_we_n),
  .lt_oe_n   (lt_oe_n),
  .lt_busy_n (lt_busy_n),
  .lt_rvalid (lt_rvalid),
  .lt_irq_n  (lt_irq_n),
  .rt_addr   (rt_addr),
  .rt_cs_n   (rt_cs_n),
  .rt_we_n   (rt_we_n),
  .rt_oe_n   (rt_oe_n),
  .rt_busy_n (rt_busy_n),
  .rt_rvalid (rt_rvalid),
  .rt_irq_n  (rt_irq_n)
);

// File: tb/mbx_irq_top_test.sv
`timescale 1ns/1ps
module mbx_irq_top_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [AW-1:0] RBOX = 12'hFFF;
  localparam logic [AW-1:0] LBOX = 12'hFFE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] lt_addr, rt_addr;
  logic          lt_cs_n, lt_we_n, lt_oe_n, lt_busy_n;
  logic          rt_cs_n, rt_we_n, rt_oe_n, rt_busy_n;
  logic [DW-1:0] lt_wdata, rt_wdata, lt_rdata, rt_rdata;
  logic          lt_rvalid, rt_rvalid, lt_irq_n, rt_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_top #(.AW(AW), .DW(DW)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    lt_cs_n = 1; lt_we_n = 1; lt_oe_n = 1; lt_busy_n = 1; lt_addr = '0; lt_wdata = '0;
    rt_cs_n = 1; rt_we_n = 1; rt_oe_n = 1; rt_busy_n = 1; rt_addr = '0; rt_wdata = '0;
  endtask

  task automatic drv_l(input logic cs, we, oe, busy, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lt_cs_n = cs; lt_we_n = we; lt_oe_n = oe; lt_busy_n = busy; lt_addr = a; lt_wdata = d;
  endtask

  task automatic drv_r(input logic cs, we, oe, busy, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rt_cs_n = cs; rt_we_n = we; rt_oe_n = oe; rt_busy_n = busy; rt_addr = a; rt_wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  task automatic t_reset();
    check("R1 left irq", lt_irq_n, 0);
    check("R1 right irq", rt_irq_n, 0);
    check("R1 rvalid", {lt_rvalid, rt_rvalid}, 0);
  endtask

  task automatic t_clear_both();
    drv_l(0, 1, 0, 1, LBOX, 0);
    drv_r(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R3 left clear", lt_irq_n, 1);
    check("R3 right clear", rt_irq_n, 1);
    check("R9 rvalid both", {lt_rvalid, rt_rvalid}, 2'b11);
    check("R1 reset word", {lt_rdata, rt_rdata}, 0);
  endtask

  task automatic t_left_posts();
    drv_l(0, 0, 1, 1, RBOX, 16'hA5A5);
    tick();
    check("R2 right set", rt_irq_n, 0);
    check("R2 left untouched", lt_irq_n, 1);
    drv_l(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R4 peer read keeps irq", rt_irq_n, 0);
    check("R9 left rvalid", lt_rvalid, 1);
    check("R9 left rdata", lt_rdata, 16'hA5A5);
    drv_r(0, 1, 0, 0, RBOX, 0);
    tick();
    check("R6 busy read keeps irq", rt_irq_n, 0);
    check("R6 busy read no rvalid", rt_rvalid, 0);
    drv_r(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R3 right clear", rt_irq_n, 1);
    check("R9 right rdata", rt_rdata, 16'hA5A5);
  endtask

  task automatic t_busy_write();
    drv_r(0, 0, 1, 0, LBOX, 16'hDEAD);
    tick();
    check("R5 busy write no set", lt_irq_n, 1);
    drv_r(0, 1, 0, 1, LBOX, 0);
    tick();
    check("R5 busy write no store", rt_rdata, 16'h0000);
    drv_r(0, 0, 1, 1, LBOX, 16'h1234);
    tick();
    check("R2 left set", lt_irq_n, 0);
    drv_l(0, 1, 0, 1, LBOX, 0);
    tick();
    check("R3 left clear", lt_irq_n, 1);
    check("R9 left own word", lt_rdata, 16'h1234);
  endtask

  task automatic t_strobes();
    drv_l(1, 0, 1, 1, RBOX, 16'h5555);
    tick();
    check("R8 cs high write ignored", rt_irq_n, 1);
    drv_l(0, 1, 1, 1, RBOX, 0);
    tick();
    check("R8 oe high no read", lt_rvalid, 0);
    drv_l(0, 0, 1, 1, RBOX, 16'h0F0F);
    tick();
    check("R2 right set again", rt_irq_n, 0);
    drv_r(0, 1, 1, 1, RBOX, 0);
    tick();
    check("R8 oe high no clear", rt_irq_n, 0);
    check("R8 oe high no rvalid", rt_rvalid, 0);
    drv_r(1, 1, 0, 1, RBOX, 0);
    tick();
    check("R8 cs high no clear", rt_irq_n, 0);
    drv_r(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R3 right clear", rt_irq_n, 1);
    check("R8 cs high write not stored", rt_rdata, 16'h0F0F);
  endtask

  task automatic t_other_writes();
    drv_l(0, 0, 1, 1, 12'h005, 16'h9999);
    drv_r(0, 1, 0, 1, 12'h005, 0);
    tick();
    check("R10 plain write no irq", {lt_irq_n, rt_irq_n}, 2'b11);
    check("R9 plain read no rvalid", rt_rvalid, 0);
    drv_r(0, 0, 1, 1, RBOX, 16'h7777);
    tick();
    check("R10 own box write no irq", rt_irq_n, 1);
    drv_l(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R10 own box write stored", lt_rdata, 16'h7777);
  endtask

  task automatic t_collide();
    drv_l(0, 0, 1, 1, RBOX, 16'hBEEF);
    drv_r(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R7 set wins", rt_irq_n, 0);
    check("R7 read sees old word", rt_rdata, 16'h7777);
    drv_r(0, 1, 0, 1, RBOX, 0);
    tick();
    check("R3 clear after collide", rt_irq_n, 1);
    check("R9 new word", rt_rdata, 16'hBEEF);
  endtask

  task automatic t_same_box();
    drv_l(0, 0, 1, 1, LBOX, 16'h1111);
    drv_r(0, 0, 1, 1, LBOX, 16'h2222);
    tick();
    check("R2 left set by right", lt_irq_n, 0);
    drv_r(0, 1, 0, 1, LBOX, 0);
    tick();
    check("R11 left data wins", rt_rdata, 16'h1111);
    drv_l(0, 1, 0, 1, LBOX, 0);
    tick();
    check("R3 left clear", lt_irq_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear_both();
    t_left_posts();
    t_busy_write();
    t_strobes();
    t_other_writes();
    t_collide();
    t_same_box();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule